// File: doc/BRIEF.md
# Serial Transmit Channel with Holding Queue

This block is the sending half of an asynchronous serial channel. A CPU writes characters into an eight-slot holding queue. A shift stage takes them one at a time and drives a start bit, the data bits least significant first, an optional parity bit and the stop bits on a single serial line. Each bit lasts one period of an external single-cycle bit-rate strobe. Between characters the line rests high.

Two status flags go back to the CPU. The ready flag says that the queue can take another character. Any write made while it is low is discarded. The empty flag marks the underrun state: the last stop bit has gone out and nothing is waiting. A two-bit command input enables, disables or resets the channel. A disable given while a character is on the line waits until that character's stop bit is done. A disable given while the channel is idle acts at once. Leaving the enabled state throws away whatever is still queued. Re-enabling brings the channel back with both flags set.

Top module: `uart_tx_channel`

## Requirements
- R1: The queue holds up to 8 characters. `tx_ready` is 1 exactly when the channel is enabled and fewer than 8 slots are in use. It updates one clock after the write or command that changes the state.
- R2: A write (`wr_en` = 1) in a cycle where `tx_ready` is 0 is not stored and is never transmitted.
- R3: A frame is one start bit of 0, then DATA_W data bits least significant first, then the parity bit when enabled, then STOP_BITS stop bits of 1. Every bit lasts from one `bit_tick` to the next. `txd` is 1 whenever no frame is being sent.
- R4: `par_mode` encodes parity: 0 = no parity bit, 1 = even (data plus parity has an even count of ones), 2 = odd, 3 = parity bit equal to `par_force`. The mode is taken when a character starts.
- R5: An enable command given while the channel is disabled sets both `tx_ready` and `tx_empty` on the next clock.
- R6: `tx_empty` goes to 1 once the last stop bit of a character has finished and no character is queued. It drops to 0 the clock after a character is written.
- R7: A disable command given while a character is on the line lets that character finish and starts no further one. The channel then becomes disabled with both flags 0, and queued characters are discarded.
- R8: A disable command given in the underrun state clears both flags on the next clock.
- R9: A reset command, like the `rst` input, stops any frame at once, drives `txd` high, clears both flags, empties the queue and leaves the channel disabled.
- R10: `cmd` encodes commands: 0 = none, 1 = enable, 2 = disable, 3 = reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle strobe at the bit rate |
| cmd | input | 2 | Channel command (R10 encoding) |
| wr_en | input | 1 | CPU write strobe |
| wr_data | input | DATA_W | Character to queue |
| par_mode | input | 2 | Parity mode (R4 encoding) |
| par_force | input | 1 | Parity value used in forced mode |
| txd | output | 1 | Serial line |
| tx_ready | output | 1 | Queue can accept a character |
| tx_empty | output | 1 | Underrun: nothing on the line or queued |

## Verification
The deferred disable is the hardest case to reach. It needs a character already on the line and another one waiting behind it at the moment the command arrives. The bench gets there by stopping the bit strobe and loading two characters, then restarting the strobe. It sends the disable as soon as it sees the start bit on `txd`. It then confirms that exactly one frame arrives and that the waiting character never appears after the channel is enabled again. The queue-full boundary is reached the same way: with the strobe stopped, eight writes fill the queue and a ninth write must be dropped.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [1:0] {
    CMD_NONE    = 2'd0,
    CMD_ENABLE  = 2'd1,
    CMD_DISABLE = 2'd2,
    CMD_RESET   = 2'd3
  } tx_cmd_e;

  typedef enum logic [1:0] {
    PAR_NONE   = 2'd0,
    PAR_EVEN   = 2'd1,
    PAR_ODD    = 2'd2,
    PAR_FORCED = 2'd3
  } par_mode_e;
endpackage

// File: rtl/tx_fifo.sv
module tx_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [CW-1:0]     count,
  output logic [CW-1:0]     count_nxt
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  assign rd_data = mem[rd_ptr];

  always_comb begin
    if (flush) count_nxt = '0;
    else       count_nxt = count + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      count <= count_nxt;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && !flush) |-> (count < CW'(DEPTH))) else $error("queue overflow"); // R1
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    pop |-> (count != '0)) else $error("queue underflow"); // R3
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
  import uart_tx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int STOP_BITS = 1,
  localparam int FW = 2 + DATA_W + STOP_BITS,
  localparam int LW = $clog2(FW + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              abort,
  input  logic              bit_tick,
  input  logic              load_ok,
  input  logic              have_char,
  input  logic [DATA_W-1:0] data,
  input  par_mode_e         par_mode,
  input  logic              par_force,
  output logic              txd,
  output logic              active,
  output logic              active_nxt,
  output logic              eof,
  output logic              pop
);
  logic [FW-1:0] sreg;
  logic [FW-1:0] frame;
  logic [LW-1:0] left;
  logic          pbit;
  logic          last;

  always_comb begin
    unique case (par_mode)
      PAR_EVEN: pbit = ^data;
      PAR_ODD:  pbit = ~^data;
      default:  pbit = par_force;
    endcase
    frame             = '1;
    frame[0]          = 1'b0;
    frame[DATA_W:1]   = data;
    if (par_mode != PAR_NONE) frame[DATA_W+1] = pbit;
  end

  assign last = (left == '0);
  assign eof  = bit_tick && active && last;
  assign pop  = bit_tick && (!active || last) && load_ok && have_char;

  always_comb begin
    if (rst || abort) active_nxt = 1'b0;
    else if (pop)     active_nxt = 1'b1;
    else if (eof)     active_nxt = 1'b0;
    else              active_nxt = active;
  end

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      active <= 1'b0;
      txd    <= 1'b1;
      left   <= '0;
      sreg   <= '1;
    end else if (pop) begin
      active <= 1'b1;
      txd    <= 1'b0;
      sreg   <= frame >> 1;
      left   <= (par_mode != PAR_NONE) ? LW'(FW - 1) : LW'(FW - 2);
    end else if (eof) begin
      active <= 1'b0;
      txd    <= 1'b1;
    end else if (bit_tick && active) begin
      txd  <= sreg[0];
      sreg <= {1'b1, sreg[FW-1:1]};
      left <= left - 1'b1;
    end
  end

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !active |-> txd) else $error("line not idle high"); // R3
  AST_HOLD_BIT: assert property (@(posedge clk) disable iff (rst)
    (!bit_tick && !abort) |=> $stable(txd)) else $error("bit changed between ticks"); // R3
endmodule

// File: rtl/tx_ctrl.sv
module tx_ctrl
  import uart_tx_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  tx_cmd_e       cmd,
  input  logic          active,
  input  logic          active_nxt,
  input  logic          eof,
  input  logic [CW-1:0] count_nxt,
  output logic          enabled,
  output logic          load_ok,
  output logic          flush,
  output logic          abort,
  output logic          tx_ready,
  output logic          tx_empty
);
  logic pending;
  logic dis_exec;
  logic en_nxt, pend_nxt;

  assign abort    = (cmd == CMD_RESET);
  assign dis_exec = enabled && ((cmd == CMD_DISABLE) || pending) && (!active || eof);
  assign flush    = abort || dis_exec;
  assign load_ok  = enabled && !pending && (cmd != CMD_DISABLE) && (cmd != CMD_RESET);

  always_comb begin
    if (abort || dis_exec)                       en_nxt = 1'b0;
    else if (cmd == CMD_ENABLE)                  en_nxt = 1'b1;
    else                                         en_nxt = enabled;
    if (abort || dis_exec || cmd == CMD_ENABLE)  pend_nxt = 1'b0;
    else if (cmd == CMD_DISABLE && enabled)      pend_nxt = 1'b1;
    else                                         pend_nxt = pending;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enabled  <= 1'b0;
      pending  <= 1'b0;
      tx_ready <= 1'b0;
      tx_empty <= 1'b0;
    end else begin
      enabled  <= en_nxt;
      pending  <= pend_nxt;
      tx_ready <= en_nxt && (count_nxt != CW'(DEPTH));
      tx_empty <= en_nxt && (count_nxt == '0) && !active_nxt;
    end
  end

  AST_ENABLE_SETS: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_ENABLE && !enabled) |=> (tx_ready && tx_empty)) else $error("enable flags"); // R5
  AST_PENDING_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    pending |-> active) else $error("pending disable without a frame"); // R7
endmodule

// File: rtl/uart_tx_channel.sv
module uart_tx_channel
  import uart_tx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int DEPTH     = 8,
  parameter int STOP_BITS = 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick,
  input  logic [1:0]        cmd,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        par_mode,
  input  logic              par_force,
  output logic              txd,
  output logic              tx_ready,
  output logic              tx_empty
);
  tx_cmd_e           cmd_e;
  logic              flush, abort, load_ok, enabled;
  logic              push, pop;
  logic              active, active_nxt, eof;
  logic [DATA_W-1:0] head;
  logic [CW-1:0]     count, count_nxt;

  assign cmd_e = tx_cmd_e'(cmd);
  assign push  = wr_en && tx_ready && !flush;

  tx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .flush(flush), .push(push), .pop(pop),
    .wr_data(wr_data), .rd_data(head), .count(count), .count_nxt(count_nxt)
  );

  tx_shifter #(.DATA_W(DATA_W), .STOP_BITS(STOP_BITS)) u_shift (
    .clk(clk), .rst(rst), .abort(abort), .bit_tick(bit_tick),
    .load_ok(load_ok), .have_char(count != '0), .data(head),
    .par_mode(par_mode_e'(par_mode)), .par_force(par_force),
    .txd(txd), .active(active), .active_nxt(active_nxt), .eof(eof), .pop(pop)
  );

  tx_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .cmd(cmd_e), .active(active), .active_nxt(active_nxt),
    .eof(eof), .count_nxt(count_nxt), .enabled(enabled), .load_ok(load_ok),
    .flush(flush), .abort(abort), .tx_ready(tx_ready), .tx_empty(tx_empty)
  );

  AST_READY_ROOM: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> (enabled && count < CW'(DEPTH))) else $error("ready with full queue"); // R1
  AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (rst)
    tx_empty |-> (!active && count == '0 && txd)) else $error("empty while busy"); // R6
  AST_DROP_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !tx_ready && !pop) |=> (count <= $past(count))) else $error("write stored while not ready"); // R2
  AST_RESET_CMD: assert property (@(posedge clk) disable iff (rst)
    (cmd_e == CMD_RESET) |=> (txd && !tx_ready && !tx_empty && count == '0)) else $error("reset command"); // R9
endmodule

// File: tb/tb_uart_tx_channel.sv
module tb_uart_tx_channel;
  localparam int DW  = 8;
  localparam int DIV = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bit_tick = 1'b0;
  logic [1:0]    cmd = 2'd0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [1:0]    par_mode = 2'd0;
  logic          par_force = 1'b0;
  logic          txd, tx_ready, tx_empty;

  uart_tx_channel #(.DATA_W(DW), .DEPTH(8), .STOP_BITS(1)) dut (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .cmd(cmd), .wr_en(wr_en),
    .wr_data(wr_data), .par_mode(par_mode), .par_force(par_force),
    .txd(txd), .tx_ready(tx_ready), .tx_empty(tx_empty)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  bit tick_on = 0;
  bit rx_ignore = 0;
  int div_cnt = 0;
  logic [DW-1:0] exp_data [2048];
  int exp_wr = 0, exp_rd = 0, rx_cnt = 0;
  int rx_st = 0, rx_i = 0;
  logic [DW-1:0] rx_sh;
  logic rx_p;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic logic exp_par(input logic [DW-1:0] d);
    case (par_mode)
      2'd1:    return ^d;
      2'd2:    return ~^d;
      default: return par_force;
    endcase
  endfunction

  // tick generator and line receiver; samples one value per bit period
  always @(negedge clk) begin
    if (bit_tick) begin
      if (rx_ignore) rx_st = 0;
      else case (rx_st)
        0: if (!txd) begin rx_st = 1; rx_i = 0; rx_sh = '0; end
        1: begin
          rx_sh[rx_i] = txd; rx_i++;
          if (rx_i == DW) rx_st = (par_mode != 2'd0) ? 2 : 3;
        end
        2: begin rx_p = txd; rx_st = 3; end
        default: begin
          chk(exp_rd < exp_wr, "R2 unexpected frame", exp_rd, exp_wr);
          if (exp_rd < exp_wr) begin
            chk(rx_sh == exp_data[exp_rd], "R3 data", rx_sh, exp_data[exp_rd]);
            if (par_mode != 2'd0)
              chk(rx_p == exp_par(exp_data[exp_rd]), "R4 parity", rx_p, exp_par(exp_data[exp_rd]));
          end
          chk(txd == 1'b1, "R3 stop bit", txd, 1);
          exp_rd++; rx_cnt++; rx_st = 0;
        end
      endcase
    end
    if (tick_on) begin
      div_cnt = (div_cnt + 1) % DIV;
      bit_tick = (div_cnt == 0);
    end else bit_tick = 1'b0;
  end

  task automatic put(input logic [DW-1:0] v, input bit wait_rdy);
    @(negedge clk);
    if (wait_rdy) while (!tx_ready) @(negedge clk);
    if (tx_ready) begin exp_data[exp_wr] = v; exp_wr++; end
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_cmd(input logic [1:0] c);
    @(negedge clk);
    cmd = c;
    @(negedge clk);
    cmd = 2'd0;
  endtask

  task automatic wait_rx(input int n);
    for (int t = 0; t < 20000 && rx_cnt < n; t++) @(negedge clk);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ticks(input bit on);
    @(negedge clk);
    tick_on = on;
    wait_cyc(2);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    int base;
    wait_cyc(3);
    rst = 1'b0;
    @(negedge clk);
    chk(tx_ready == 0, "R9 reset ready", tx_ready, 0);
    chk(tx_empty == 0, "R9 reset empty", tx_empty, 0);
    chk(txd == 1, "R9 reset line", txd, 1);

    // R2: write while disabled is dropped
    tick_on = 1;
    put(8'h5A, 0);
    chk(tx_ready == 0, "R2 still not ready", tx_ready, 0);
    do_cmd(2'd1);                        // R10 enable
    chk(tx_ready == 1, "R5 ready on enable", tx_ready, 1);
    chk(tx_empty == 1, "R5 empty on enable", tx_empty, 1);
    wait_cyc(60);
    chk(rx_cnt == 0, "R2 dropped char not sent", rx_cnt, 0);

    // R3/R4 sweep: all values in each parity mode, forced with both values
    for (int m = 0; m < 5; m++) begin
      @(negedge clk);
      par_mode  = (m == 4) ? 2'd3 : 2'(m);
      par_force = (m == 4);
      for (int v = 0; v < 256; v++) put(8'(v), 1);
      wait_rx(exp_wr);
      wait_cyc(4 * DIV);
      chk(tx_empty == 1, "R6 underrun after drain", tx_empty, 1);
      chk(tx_ready == 1, "R1 ready after drain", tx_ready, 1);
    end

    // R1: fill boundary with ticks stopped
    set_ticks(0);
    par_mode = 2'd1;
    base = rx_cnt;
    for (int k = 0; k < 8; k++) begin
      put(8'(8'hA0 + k), 0);
      if (k == 0) chk(tx_empty == 0, "R6 empty clears on write", tx_empty, 0);
      chk(tx_ready == (k < 7), "R1 ready vs occupancy", tx_ready, (k < 7));
    end
    put(8'hFF, 0);                       // R2: ninth write dropped
    chk(exp_wr - exp_rd == 8, "R2 ninth not queued", exp_wr - exp_rd, 8);
    set_ticks(1);
    wait_rx(base + 8);
    wait_cyc(30 * DIV);
    chk(rx_cnt == base + 8, "R2 exactly eight frames", rx_cnt - base, 8);
    chk(tx_empty == 1, "R6 underrun after fill", tx_empty, 1);

    // R7: deferred disable
    set_ticks(0);
    put(8'h3C, 0);
    put(8'hC3, 0);
    base = rx_cnt;
    @(negedge clk); tick_on = 1;
    while (txd) @(negedge clk);
    do_cmd(2'd2);                        // R10 disable
    chk(tx_ready == 1, "R7 ready while pending", tx_ready, 1);
    wait_rx(base + 1);
    wait_cyc(4 * DIV);
    chk(tx_ready == 0, "R7 ready after pending disable", tx_ready, 0);
    chk(tx_empty == 0, "R7 empty after pending disable", tx_empty, 0);
    chk(txd == 1, "R7 line idle", txd, 1);
    exp_rd = exp_wr;                     // second char was discarded
    do_cmd(2'd1);
    chk(tx_ready == 1 && tx_empty == 1, "R5 re-enable flags", {tx_ready, tx_empty}, 3);
    wait_cyc(40 * DIV);
    chk(rx_cnt == base + 1, "R7 queued char discarded", rx_cnt - base, 1);

    // R8: disable in underrun
    do_cmd(2'd2);
    chk(tx_ready == 0 && tx_empty == 0, "R8 immediate disable", {tx_ready, tx_empty}, 0);

    // R9: reset command mid-frame
    do_cmd(2'd1);
    put(8'h81, 0);
    while (txd) @(negedge clk);
    rx_ignore = 1;
    do_cmd(2'd3);                        // R10 reset
    chk(txd == 1, "R9 frame aborted", txd, 1);
    chk(tx_ready == 0 && tx_empty == 0, "R9 flags cleared", {tx_ready, tx_empty}, 0);
    wait_cyc(20 * DIV);
    chk(txd == 1, "R9 line stays idle", txd, 1);
    exp_rd = exp_wr;
    rx_ignore = 0;
    base = rx_cnt;
    put(8'h66, 0);                       // R2: dropped while disabled after reset
    do_cmd(2'd1);
    chk(tx_empty == 1, "R9 queue emptied by reset", tx_empty, 1);
    wait_cyc(40 * DIV);
    chk(rx_cnt == base, "R2 no frame after reset", rx_cnt - base, 0);

    finish_run();
  end
endmodule